// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block holds the program counter of a single-cycle processor, looks up the instruction word that the counter addresses, and works out the counter value for the next cycle. The instruction store is a small read-only array inside the block. Its read is purely combinational, so the word for the current PC appears in the same cycle the PC changes.

On each rising clock edge the PC normally moves on by four bytes. The datapath drives two inputs for a conditional branch on register equality. One is a branch-select from the decoder. The other is an equality flag from the register comparison. When both are high in a cycle, the next PC is the sequential address plus the low 16 bits of the current instruction. That offset is sign-extended and scaled to bytes by appending two zero bits. The array contents come from a fixed formula in the package, which gives a known program with short forward and backward branch offsets. Addresses past the end of the array read as zero.

Top module: `ifu_fetch_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0, and it becomes 0 as soon as rst_ni falls, without waiting for a clock edge.
- R2: On a rising edge where br_sel_i and eq_i are not both high, pc_o becomes its previous value plus 4.
- R3: On a rising edge where br_sel_i and eq_i are both high, pc_o becomes previous pc_o + 4 + ({sign-extended instr_o[15:0], 2'b00}), using the instr_o of that same cycle.
- R4: br_sel_i high with eq_i low, or eq_i high with br_sel_i low, has no effect on the next PC (it still steps by 4).
- R5: instr_o is the array word at index pc_o[31:2] in the same cycle that pc_o takes its value; no clock edge lies between them.
- R6: The array word at index i is {i[15:0], imm}, where imm is the 16-bit two's-complement value (i mod 7) - 3.
- R7: When pc_o[31:2] is at least IMEM_WORDS, instr_o is 32'h0, so a taken branch from such an address adds an offset of zero.
- R8: All PC arithmetic wraps modulo 2^32 (a backward branch from 0 gives an address near 2^32, and stepping past 32'hFFFFFFFC gives 0).
- R9: pc_o[1:0] is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_sel_i | input | 1 | Current instruction is a conditional branch on equality |
| eq_i | input | 1 | The two compared registers are equal |
| pc_o | output | 32 | Current program counter (byte address) |
| instr_o | output | 32 | Instruction word at pc_o |

## Verification
The bench builds the block with IMEM_WORDS = 16. With that size a short run of taken branches leaves the array, so the zero word read past the end and the zero offset it gives a taken branch can both be checked. Because the offset pattern repeats every seven words, the small array still holds every offset from -3 to +3, including a branch to its own address. A taken branch at index 0 has offset -3, so it wraps below zero. That reaches the modulo-2^32 wrap in both directions, backward into the top of the address space and forward back to 0, in only three cycles.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned PC_W    = 32;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned OFF_MOD  = 7;
  localparam int unsigned OFF_BIAS = 3;

  typedef logic [PC_W-1:0]    pc_t;
  typedef logic [INSTR_W-1:0] instr_t;
  typedef logic [IMM_W-1:0]   imm_t;

  // built-in program: upper half tags the index, lower half is a small offset
  function automatic instr_t rom_word(input int unsigned idx);
    logic [IMM_W-1:0] tag;
    imm_t             off;
    tag = IMM_W'(idx);
    off = IMM_W'(idx % OFF_MOD) - IMM_W'(OFF_BIAS);
    return {tag, off};
  endfunction
endpackage

// File: rtl/ifu_imem.sv
module ifu_imem
  import ifu_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 16
) (
  input  pc_t    addr_i,
  output instr_t data_o
);
  localparam int unsigned IDX_W = (IMEM_WORDS > 1) ? $clog2(IMEM_WORDS) : 1;

  instr_t           rom [IMEM_WORDS];
  logic [PC_W-3:0]  word_idx;
  logic             in_range;

  for (genvar g = 0; g < IMEM_WORDS; g++) begin : g_rom
    assign rom[g] = rom_word(g);
  end

  assign word_idx = addr_i[PC_W-1:2];
  assign in_range = (word_idx < (PC_W-2)'(IMEM_WORDS));

  always_comb begin
    data_o = '0;
    if (in_range) data_o = rom[word_idx[IDX_W-1:0]];
  end
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
  import ifu_pkg::*;
(
  input  pc_t  pc_i,
  input  imm_t imm_i,
  input  logic take_i,
  output pc_t  next_o
);
  localparam int unsigned EXT_W = PC_W - IMM_W - 2;

  pc_t seq_pc;
  pc_t off_bytes;
  pc_t tgt_pc;

  assign seq_pc    = pc_i + PC_W'(4);
  assign off_bytes = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign tgt_pc    = seq_pc + off_bytes;
  assign next_o    = take_i ? tgt_pc : seq_pc;
endmodule

// File: rtl/ifu_fetch_unit.sv
module ifu_fetch_unit
  import ifu_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        br_sel_i,
  input  logic        eq_i,
  output logic [31:0] pc_o,
  output logic [31:0] instr_o
);
  pc_t    pc_q;
  pc_t    pc_d;
  instr_t instr;
  logic   take;

  assign take = br_sel_i & eq_i;

  ifu_imem #(.IMEM_WORDS(IMEM_WORDS)) u_imem (
    .addr_i (pc_q),
    .data_o (instr)
  );

  ifu_next_pc u_npc (
    .pc_i   (pc_q),
    .imm_i  (instr[IMM_W-1:0]),
    .take_i (take),
    .next_o (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o    = pc_q;
  assign instr_o = instr;
endmodule

// File: rtl/ifu_fetch_chk.sv
module ifu_fetch_chk #(
  parameter int unsigned IMEM_WORDS = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        br_sel_i,
  input logic        eq_i,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o
);
  // R2 and R4: anything short of both inputs high steps by 4
  p_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br_sel_i && eq_i) |=> pc_o == $past(pc_o) + 32'd4);

  // R3 and R8: taken branch uses the offset of the word fetched that cycle
  p_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_sel_i && eq_i) |=> pc_o == $past(pc_o) + 32'd4 +
      {{14{$past(instr_o[15])}}, $past(instr_o[15:0]), 2'b00});

  p_oor_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_o[31:2] >= 30'(IMEM_WORDS)) |-> instr_o == 32'h0);

  p_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);
endmodule

bind ifu_fetch_unit ifu_fetch_chk #(.IMEM_WORDS(IMEM_WORDS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .br_sel_i (br_sel_i),
  .eq_i     (eq_i),
  .pc_o     (pc_o),
  .instr_o  (instr_o)
);

// File: tb/sim_ifu_fetch_unit.sv
`timescale 1ns/1ps
module sim_ifu_fetch_unit;
  localparam int unsigned WORDS = 16;
  localparam int unsigned NVEC  = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br = 1'b0;
  logic        eq = 1'b0;
  logic [31:0] pc;
  logic [31:0] instr;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  ifu_fetch_unit #(.IMEM_WORDS(WORDS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .br_sel_i(br), .eq_i(eq),
    .pc_o(pc), .instr_o(instr)
  );

  // {br, eq, expected pc after the edge}, walked from pc = 0
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 32'd4},   // R4 select alone
    {1'b0, 1'b1, 32'd8},   // R4 equal alone
    {1'b1, 1'b1, 32'd8},   // R3 offset -1: self loop
    {1'b0, 1'b0, 32'd12},  // R2
    {1'b1, 1'b1, 32'd16},  // R3 offset 0
    {1'b1, 1'b1, 32'd24},  // R3 offset +1
    {1'b1, 1'b1, 32'd40},  // R3 offset +3
    {1'b1, 1'b1, 32'd44},  // R3 offset 0
    {1'b1, 1'b1, 32'd52},  // R3 offset +1
    {1'b1, 1'b1, 32'd68},  // R3 offset +3, leaves array
    {1'b1, 1'b1, 32'd72},  // R7 zero word, zero offset
    {1'b0, 1'b0, 32'd76}   // R2 beyond array
  };

  // R6/R7 expectation
  function automatic logic [31:0] exp_word(input logic [31:0] a);
    logic [29:0] i;
    logic [15:0] off;
    i = a[31:2];
    if (i >= 30'(WORDS)) return 32'h0;
    off = 16'(int'(i % 7) - 3);
    return {i[15:0], off};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic e);
    br = b;
    eq = e;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pc", pc, 32'h0);
    check("R6 word 0", instr, 32'h0000_FFFD);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k][33], VEC[k][32]);
      check($sformatf("R2/R3/R4 vec %0d pc", k), pc, VEC[k][31:0]);
      check($sformatf("R5/R6/R7 vec %0d instr", k), instr, exp_word(VEC[k][31:0]));
    end
    check("R9 alignment", {30'h0, pc[1:0]}, 32'h0);

    // R1: asynchronous reset mid-cycle
    #1 rst_n = 1'b0;
    #1 check("R1 async reset", pc, 32'h0);
    br = 1'b1; eq = 1'b1;
    @(negedge clk);
    check("R1 held in reset", pc, 32'h0);
    br = 1'b0; eq = 1'b0;
    rst_n = 1'b1;

    // R8: branch -3 from 0 wraps downward
    step(1'b1, 1'b1);
    check("R8 backward wrap", pc, 32'hFFFF_FFF8);
    check("R7 top of space", instr, 32'h0);
    step(1'b1, 1'b1);
    check("R7 zero offset", pc, 32'hFFFF_FFFC);
    step(1'b0, 1'b0);
    check("R8 forward wrap", pc, 32'h0);
    check("R5 word after wrap", instr, 32'h0000_FFFD);

    // R3 backward offset -2 from index 1 lands on index 0
    step(1'b0, 1'b0);
    check("R2 step to 4", pc, 32'd4);
    step(1'b1, 1'b1);
    check("R3 offset -2", pc, 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule